// File: doc/BRIEF.md
# Double-Buffered Full-Duplex Serial Port

This block is a byte-wide serial port with one control register and one data register address. It works in four modes: a synchronous shift mode and three asynchronous modes. The asynchronous modes are an 8-bit frame, a 9-bit frame at a fixed rate, and a 9-bit frame at a variable rate. The transmitter and the receiver run at the same time. A write to the data address loads the transmit shifter. A read from the same address returns a separate receive holding register, so software never sees its own transmitted byte.

In the asynchronous modes, timing comes from a 16x oversample strobe. Modes 1 and 3 take this strobe from an external timer overflow pulse; mode 2 takes it from a fixed clock-divide tick. The receiver votes on three samples per bit. It stores a finished frame in a holding register, which leaves its shifter free to take the next frame before software reads the last one. In the 9-bit modes, a multiprocessor filter drops any frame whose ninth bit is 0.

In synchronous mode the receive-pin output drives the shift clock, the transmit pin carries the outgoing data, and the receive pin is sampled for incoming data. Each bit lasts `SYNC_DIV` clock cycles. The interrupt request is the OR of the two event flags.

Top module: `dbl_serial_port`

## Requirements
- R1: After reset, txd_o and rxd_o are 1, irq_o is 0, and both register addresses read 0x00.
- R2: The control register (reg_sel_i=0) holds mode in bits [1:0], receive enable in bit 2, multiprocessor enable in bit 3, transmit ninth bit in bit 4, received ninth bit in bit 5 (read-only), transmit flag in bit 6 and receive flag in bit 7. Only hardware sets a flag. A write with 0 in a flag bit clears that flag, and a write with 1 leaves it unchanged. irq_o is high while either flag is set.
- R3: In modes 1 to 3, a data write (reg_sel_i=1) sends a frame LSB first: a 0 start bit, 8 data bits, then (modes 2 and 3 only) the transmit ninth bit, then a 1 stop bit. Each bit lasts 16 oversample strobes. The transmit flag is set when the stop bit ends.
- R4: A data write made while a transmission is in progress has no effect on the frame being sent.
- R5: Modes 1 and 3 take their oversample strobe from ovf_tick_i, and mode 2 takes it from div_tick_i.
- R6: In mode 0, a data write starts an 8-bit exchange with bits of SYNC_DIV cycles each. rxd_o is low for the first half of each bit and high for the second half. txd_o carries the written byte LSB first. rxd_i is captured, LSB first, at each rising edge of rxd_o. At the end the transmit flag is set. If receive is enabled and the receive flag is clear, the captured byte goes to the holding register and the receive flag is set.
- R7: The asynchronous receiver takes the majority of oversamples 7, 8 and 9 of each bit. If the start bit votes high, the receiver drops it and returns to idle without delivering a frame.
- R8: A read of the data address returns the receive holding register, never the transmitted byte.
- R9: A new frame can be received while the holding register is unread. The held byte stays unchanged until a later frame is accepted. A frame that ends while the receive flag is set is discarded, and the holding register and received ninth bit stay unchanged.
- R10: With receive enable at 0, finished frames are discarded.
- R11: In modes 2 and 3 with multiprocessor enable set, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is accepted. An accepted frame stores its ninth bit (mode 1: its stop bit) as the received ninth bit.
- R12: A frame can be transmitted and another received during the same interval, and both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Receive pin (serial data in) |
| txd_o | output | 1 | Transmit pin (serial data out) |
| rxd_o | output | 1 | Shift clock in mode 0, held high otherwise |
| ovf_tick_i | input | 1 | Timer overflow strobe, 16x bit rate, modes 1 and 3 |
| div_tick_i | input | 1 | Fixed divided-clock strobe, 16x bit rate, mode 2 |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 data |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected address |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that software does not change the mode while a transmission is in progress. They also assume that each oversample strobe lasts one clock cycle and that strobes are separated by idle cycles. The bench keeps to these rules. It changes the control register only between frames, after it has waited out the stop bit. It drives each strobe from a free-running counter with a fixed gap. The receive pin is driven with whole bit times of exactly 16 strobes, so the three voting samples always fall inside a bit.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC = 2'd0,
    MODE_UART8 = 2'd1,
    MODE_FIX9 = 2'd2,
    MODE_VAR9 = 2'd3
  } sport_mode_e;

  localparam int OS_RATE = 16;

  function automatic logic is_nine(sport_mode_e m);
    return m[1];
  endfunction

  // index of the stop bit, counting the start bit as index 0
  function automatic logic [3:0] stop_index(sport_mode_e m);
    return is_nine(m) ? 4'd10 : 4'd9;
  endfunction

  function automatic logic vote3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // serial image, bit 0 leaves first
  function automatic logic [10:0] tx_image(logic [7:0] d, logic b9, sport_mode_e m);
    if (m == MODE_SYNC) return {3'b111, d};
    if (is_nine(m))     return {1'b1, b9, d, 1'b0};
    return {2'b11, d, 1'b0};
  endfunction

  function automatic logic frame_ok(logic en, logic full, logic mp, logic nine, logic b9);
    return en && !full && (!(mp && nine) || b9);
  endfunction

endpackage

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int SYNC_DIV = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  sport_mode_e mode_i,
  input  logic [7:0]  data_i,
  input  logic        bit9_i,
  input  logic        os_tick_i,
  input  logic        sdata_i,
  output logic        txd_o,
  output logic        sclk_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  cap_o
);
  localparam int CNT_MAX = (SYNC_DIV > OS_RATE) ? SYNC_DIV : OS_RATE;
  localparam int CW = $clog2(CNT_MAX);
  localparam int HALF = SYNC_DIV / 2;

  logic          busy, done;
  logic [10:0]   sh;
  logic [3:0]    bitn;
  logic [CW-1:0] sub;
  logic [7:0]    cap;

  logic       sync_m, step, bit_end, smp;
  logic [3:0] last;

  assign sync_m  = (mode_i == MODE_SYNC);
  assign last    = sync_m ? 4'd7 : stop_index(mode_i);
  assign step    = busy && (sync_m || os_tick_i);
  assign bit_end = step && (sub == (sync_m ? CW'(SYNC_DIV - 1) : CW'(OS_RATE - 1)));
  assign smp     = busy && sync_m && (sub == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sh   <= '1;
      bitn <= '0;
      sub  <= '0;
      cap  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1;
          sh   <= tx_image(data_i, bit9_i, mode_i);
          bitn <= '0;
          sub  <= '0;
        end
      end else begin
        if (smp) cap <= {sdata_i, cap[7:1]};
        if (bit_end) begin
          sub  <= '0;
          sh   <= {1'b1, sh[10:1]};
          bitn <= bitn + 4'd1;
          if (bitn == last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else if (step) begin
          sub <= sub + CW'(1);
        end
      end
    end
  end

  assign txd_o  = busy ? sh[0] : 1'b1;
  assign sclk_o = (busy && sync_m) ? (sub >= CW'(HALF)) : 1'b1;
  assign busy_o = busy;
  assign done_o = done;
  assign cap_o  = cap;
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick_i,
  input  logic       nine_i,
  input  logic       rxd_i,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       bit9_o
);
  logic       act, done, s7, s8, b9;
  logic [3:0] sub, idx;
  logic [7:0] data;

  logic       v, at_vote, start_det;
  logic [3:0] last;

  assign v         = vote3(s7, s8, rxd_i);
  assign at_vote   = act && os_tick_i && (sub == 4'd9);
  assign last      = nine_i ? 4'd10 : 4'd9;
  assign start_det = !act && os_tick_i && !rxd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      done <= 1'b0;
      s7   <= 1'b1;
      s8   <= 1'b1;
      b9   <= 1'b0;
      sub  <= '0;
      idx  <= '0;
      data <= '0;
    end else begin
      done <= 1'b0;
      if (start_det) begin
        act <= 1'b1;
        sub <= 4'd1;
        idx <= 4'd0;
      end else if (act && os_tick_i) begin
        sub <= sub + 4'd1;
        if (sub == 4'd15) idx <= idx + 4'd1;
        if (sub == 4'd7) s7 <= rxd_i;
        if (sub == 4'd8) s8 <= rxd_i;
        if (at_vote) begin
          if (idx == 4'd0) begin
            if (v) act <= 1'b0;
          end else if (idx <= 4'd8) begin
            data <= {v, data[7:1]};
          end else if (idx == last) begin
            if (!nine_i) b9 <= v;
            act  <= 1'b0;
            done <= 1'b1;
          end else begin
            b9 <= v;
          end
        end
      end
    end
  end

  assign done_o = done;
  assign byte_o = data;
  assign bit9_o = b9;
endmodule

// File: rtl/dbl_serial_port.sv
module dbl_serial_port
  import sport_pkg::*;
#(
  parameter int SYNC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       rxd_o,
  input  logic       ovf_tick_i,
  input  logic       div_tick_i,
  input  logic       reg_we_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  sport_mode_e mode;
  logic rx_en, mp_en, tx_b9, rx_b9, tx_flag, rx_flag;
  logic [7:0] rx_hold;
  logic [1:0] rx_sync;
  logic rx_s;

  // named internal events
  logic ctrl_wr, data_wr, os_tick;
  logic tx_busy, tx_done, sync_done, async_done, rx_accept;
  logic [7:0] sync_cap, async_byte, in_byte;
  logic async_b9, in_nine;

  assign ctrl_wr = reg_we_i && !reg_sel_i;
  assign data_wr = reg_we_i && reg_sel_i;
  assign os_tick = (mode == MODE_FIX9) ? div_tick_i : ovf_tick_i;
  assign rx_s    = rx_sync[1];

  sport_tx #(.SYNC_DIV(SYNC_DIV)) i_tx (
    .clk(clk), .rst_n(rst_n), .start_i(data_wr), .mode_i(mode),
    .data_i(reg_wdata_i), .bit9_i(tx_b9), .os_tick_i(os_tick),
    .sdata_i(rx_s), .txd_o(txd_o), .sclk_o(rxd_o), .busy_o(tx_busy),
    .done_o(tx_done), .cap_o(sync_cap)
  );

  logic rx_tick;
  logic rx_done_raw;
  assign rx_tick = os_tick && (mode != MODE_SYNC);

  sport_rx i_rx (
    .clk(clk), .rst_n(rst_n), .os_tick_i(rx_tick), .nine_i(is_nine(mode)),
    .rxd_i(rx_s), .done_o(rx_done_raw), .byte_o(async_byte), .bit9_o(async_b9)
  );

  assign sync_done  = tx_done && (mode == MODE_SYNC);
  assign async_done = rx_done_raw && (mode != MODE_SYNC);
  assign in_byte    = sync_done ? sync_cap : async_byte;
  assign in_nine    = async_done && is_nine(mode);
  assign rx_accept  = (sync_done || async_done) &&
                      frame_ok(rx_en, rx_flag, mp_en, in_nine, async_b9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      mode    <= MODE_SYNC;
      rx_en   <= 1'b0;
      mp_en   <= 1'b0;
      tx_b9   <= 1'b0;
      rx_b9   <= 1'b0;
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
      rx_hold <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd_i};
      if (ctrl_wr) begin
        mode  <= sport_mode_e'(reg_wdata_i[1:0]);
        rx_en <= reg_wdata_i[2];
        mp_en <= reg_wdata_i[3];
        tx_b9 <= reg_wdata_i[4];
      end
      tx_flag <= (tx_flag & (!ctrl_wr || reg_wdata_i[6])) | tx_done;
      rx_flag <= (rx_flag & (!ctrl_wr || reg_wdata_i[7])) | rx_accept;
      if (rx_accept) begin
        rx_hold <= in_byte;
        if (async_done) rx_b9 <= async_b9;
      end
    end
  end

  assign reg_rdata_o = reg_sel_i ? rx_hold
                                 : {rx_flag, tx_flag, rx_b9, tx_b9, mp_en, rx_en, mode};
  assign irq_o = rx_flag | tx_flag;
endmodule

// File: rtl/sport_chk.sv
module sport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [7:0] wdata,
  input logic       tx_flag,
  input logic       rx_flag,
  input logic       tx_done,
  input logic       tx_busy,
  input logic       rx_accept,
  input logic [7:0] rx_hold,
  input logic       mp_en,
  input logic [1:0] mode,
  input logic       rx_b9,
  input logic       txd_o
);
  p_rx_flag_sw_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flag) |-> $past(ctrl_wr && !wdata[7]));

  p_tx_flag_sw_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flag) |-> $past(ctrl_wr && !wdata[6]));

  p_tx_flag_set_by_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> $past(tx_done));

  p_stop_bit_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && mode != 2'd0) |-> $past(txd_o));

  p_hold_changes_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_hold) |-> $past(rx_accept));

  p_full_hold_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !ctrl_wr) |=> $stable(rx_hold));

  p_mp_ninth_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && mp_en && mode[1]) |=> rx_b9);
endmodule

bind dbl_serial_port sport_chk i_sport_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(reg_wdata_i),
  .tx_flag(tx_flag), .rx_flag(rx_flag), .tx_done(tx_done), .tx_busy(tx_busy),
  .rx_accept(rx_accept), .rx_hold(rx_hold), .mp_en(mp_en), .mode(mode),
  .rx_b9(rx_b9), .txd_o(txd_o)
);

// File: tb/test_dbl_serial_port.sv
module test_dbl_serial_port;
  localparam int OVF_P = 4;
  localparam int DIV_P = 6;
  localparam int SDIV  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd_i = 1'b1, ovf_tick_i = 1'b0, div_tick_i = 1'b0;
  logic reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic txd_o, rxd_o, irq_o;
  logic [7:0] reg_rdata_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [10:0] got;
  logic [7:0] rd, last_hold;

  dbl_serial_port #(.SYNC_DIV(SDIV)) i_dbl_serial_port (.*);

  always #2 clk = ~clk;

  initial begin
    int co = 0, cd = 0;
    forever begin
      @(negedge clk);
      cyc++;
      ovf_tick_i = (co == OVF_P - 1);
      div_tick_i = (cd == DIV_P - 1);
      co = (co + 1) % OVF_P;
      cd = (cd + 1) % DIV_P;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [10:0] frame_of(int mode, logic [7:0] d, logic b9);
    if (mode == 1) return {1'b1, 1'b1, d, 1'b0};
    return {1'b1, b9, d, 1'b0};
  endfunction
  function automatic int per_of(int mode);
    return (mode == 2) ? DIV_P : OVF_P;
  endfunction
  function automatic int len_of(int mode);
    return (mode == 1) ? 10 : 11;
  endfunction
  function automatic logic [7:0] ctl(int mode, logic en, logic mp, logic b9, logic keep);
    return {keep, keep, 1'b0, b9, mp, en, mode[1:0]};
  endfunction

  task automatic check(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rdreg(logic sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel_i = sel;
    #1 v = reg_rdata_o;
  endtask

  task automatic send_rx(int p, int n, logic [10:0] f);
    for (int i = 0; i < n; i++) begin
      rxd_i = f[i];
      repeat (16 * p) @(negedge clk);
    end
    rxd_i = 1'b1;
  endtask

  task automatic decode_tx(int p, int n);
    got = '1;
    @(negedge clk);
    while (txd_o) @(negedge clk);
    repeat (8 * p) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd_o;
      if (i < n - 1) repeat (16 * p) @(negedge clk);
    end
  endtask

  task automatic tx_frame(int mode, logic [7:0] d, logic b9, string req);
    wr(1'b0, ctl(mode, 1'b1, 1'b0, b9, 1'b0));
    fork
      decode_tx(per_of(mode), len_of(mode));
      wr(1'b1, d);
    join
    check(got == frame_of(mode, d, b9), req, got, frame_of(mode, d, b9));
    repeat (12 * per_of(mode)) @(negedge clk);
  endtask

  initial begin
    logic [7:0] e, d;
    int fall0, fall1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd_o == 1'b1 && rxd_o == 1'b1, "R1 idle pins", {txd_o, rxd_o}, 3);
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    rdreg(1'b0, rd); check(rd == 8'h00, "R1 control", rd, 0);
    rdreg(1'b1, rd); check(rd == 8'h00, "R1 data", rd, 0);

    // R2 layout, read-only bit 5, flags not set by software
    wr(1'b0, 8'hFF);
    rdreg(1'b0, rd); check(rd == 8'h1F, "R2 writable fields", rd, 8'h1F);
    check(irq_o == 1'b0, "R2 irq stays low", irq_o, 0);

    // R3 transmit mode 1, with R4 extra write mid-frame
    wr(1'b0, ctl(1, 1'b1, 1'b0, 1'b0, 1'b0));
    fork
      decode_tx(OVF_P, 10);
      begin wr(1'b1, 8'hA5); repeat (40 * OVF_P) @(negedge clk); wr(1'b1, 8'h3C); end
    join
    check(got == frame_of(1, 8'hA5, 1'b0), "R4 busy write ignored", got, frame_of(1, 8'hA5, 1'b0));
    repeat (12 * OVF_P) @(negedge clk);
    rdreg(1'b0, rd); check(rd[6] == 1'b1, "R3 tx flag set", rd[6], 1);
    check(irq_o == 1'b1, "R2 irq on flag", irq_o, 1);
    wr(1'b0, ctl(1, 1'b1, 1'b0, 1'b0, 1'b0));
    rdreg(1'b0, rd); check(rd[7:6] == 2'b00, "R2 write-0 clears", rd[7:6], 0);
    check(irq_o == 1'b0, "R2 irq cleared", irq_o, 0);

    // R5 mode 2 uses div tick, mode 3 uses ovf tick
    tx_frame(2, 8'h81, 1'b1, "R5 mode 2 frame");
    tx_frame(3, 8'h7E, 1'b0, "R5 mode 3 frame");

    // R8 receive mode 1
    wr(1'b0, ctl(1, 1'b1, 1'b0, 1'b0, 1'b0));
    send_rx(OVF_P, 10, frame_of(1, 8'h5A, 1'b1));
    repeat (4) @(negedge clk);
    rdreg(1'b1, rd); check(rd == 8'h5A, "R8 data read is receive side", rd, 8'h5A);
    rdreg(1'b0, rd); check(rd[7] && rd[5], "R11 mode 1 stop bit stored", rd, 8'hA5);
    last_hold = 8'h5A;

    // R9 second frame while full: discarded
    send_rx(OVF_P, 10, frame_of(1, 8'hC3, 1'b1));
    repeat (4) @(negedge clk);
    rdreg(1'b1, rd); check(rd == 8'h5A, "R9 frame while full dropped", rd, 8'h5A);

    // R9 double buffer: clear flag during next reception
    fork
      send_rx(OVF_P, 10, frame_of(1, 8'h96, 1'b1));
      begin
        repeat (16 * OVF_P * 5) @(negedge clk);
        rdreg(1'b1, rd); check(rd == 8'h5A, "R9 held byte during reception", rd, 8'h5A);
        wr(1'b0, ctl(1, 1'b1, 1'b0, 1'b0, 1'b0));
      end
    join
    repeat (4) @(negedge clk);
    rdreg(1'b1, rd); check(rd == 8'h96, "R9 next frame delivered", rd, 8'h96);
    wr(1'b0, ctl(1, 1'b1, 1'b0, 1'b0, 1'b0));

    // R7 false start rejected
    rxd_i = 1'b0; repeat (3 * OVF_P) @(negedge clk); rxd_i = 1'b1;
    repeat (16 * OVF_P * 12) @(negedge clk);
    rdreg(1'b0, rd); check(rd[7] == 1'b0, "R7 glitch gives no frame", rd[7], 0);
    rdreg(1'b1, rd); check(rd == 8'h96, "R7 hold unchanged", rd, 8'h96);

    // R10 receive disabled
    wr(1'b0, ctl(1, 1'b0, 1'b0, 1'b0, 1'b0));
    send_rx(OVF_P, 10, frame_of(1, 8'h11, 1'b1));
    repeat (4) @(negedge clk);
    rdreg(1'b0, rd); check(rd[7] == 1'b0, "R10 flag stays clear", rd[7], 0);
    rdreg(1'b1, rd); check(rd == 8'h96, "R10 hold unchanged", rd, 8'h96);

    // R11 multiprocessor filter, mode 3
    wr(1'b0, ctl(3, 1'b1, 1'b1, 1'b0, 1'b0));
    send_rx(OVF_P, 11, frame_of(3, 8'h22, 1'b0));
    repeat (4) @(negedge clk);
    rdreg(1'b0, rd); check(rd[7] == 1'b0, "R11 ninth bit 0 dropped", rd[7], 0);
    send_rx(OVF_P, 11, frame_of(3, 8'h44, 1'b1));
    repeat (4) @(negedge clk);
    rdreg(1'b1, rd); check(rd == 8'h44, "R11 ninth bit 1 accepted", rd, 8'h44);
    rdreg(1'b0, rd); check(rd[7] && rd[5], "R11 ninth bit stored", rd, 8'hAF);

    // R6 synchronous exchange
    wr(1'b0, ctl(0, 1'b1, 1'b0, 1'b0, 1'b0));
    d = 8'hB4; e = 8'h69; got = '1; fall0 = 0; fall1 = 0;
    fork
      wr(1'b1, d);
      for (int i = 0; i < 8; i++) begin
        do @(negedge clk); while (rxd_o);
        if (i == 0) fall0 = cyc;
        if (i == 1) fall1 = cyc;
        rxd_i = e[i];
        do @(negedge clk); while (!rxd_o);
        got[i] = txd_o;
      end
    join
    rxd_i = 1'b1;
    repeat (SDIV + 4) @(negedge clk);
    check(got[7:0] == d, "R6 shifted-out data", got[7:0], d);
    check(fall1 - fall0 == SDIV, "R6 bit period", fall1 - fall0, SDIV);
    rdreg(1'b1, rd); check(rd == e, "R6 captured data", rd, e);
    rdreg(1'b0, rd); check(rd[7:6] == 2'b11, "R6 both flags", rd[7:6], 3);
    last_hold = e;

    // R12 random full-duplex traffic, checked with R9 and R11 expectations
    for (int it = 0; it < 10; it++) begin
      int m;
      logic mp, b9, eb9, acc;
      m = 1 + int'($urandom % 3);
      mp = 1'($urandom); b9 = 1'($urandom); eb9 = 1'($urandom);
      d = 8'($urandom); e = 8'($urandom);
      wr(1'b0, ctl(m, 1'b1, mp, b9, 1'b0));
      fork
        decode_tx(per_of(m), len_of(m));
        wr(1'b1, d);
        send_rx(per_of(m), len_of(m), frame_of(m, e, eb9));
      join
      repeat (12 * per_of(m)) @(negedge clk);
      check(got == frame_of(m, d, b9), "R12 tx frame", got, frame_of(m, d, b9));
      acc = !(mp && m >= 2) || eb9;
      if (acc) last_hold = e;
      rdreg(1'b1, rd); check(rd == last_hold, "R12 rx hold", rd, last_hold);
      rdreg(1'b0, rd);
      check(rd[7] == acc && rd[6] == 1'b1, "R11 random flags", rd[7:6], {acc, 1'b1});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule